// File: doc/BRIEF.md
# Pair-Balanced Pulse Modulator for a High-Frequency-Link Inverter

This block turns a stream of duty commands into the switching control signals of a single-phase inverter whose power passes through a high-frequency transformer. A single free-running counter defines the carrier. On the last clock of each carrier period the block takes in one duty command. The pulses of the transformer primary are grouped in pairs of consecutive carrier periods. Both pulses of a pair get the same width, which is the truncated mean of the two latest commands. The pair is split between the two diagonals of the primary bridge by a steering square wave that toggles every carrier period. As a result, each diagonal carries the same volt-seconds within a pair, and no slowly varying envelope builds up flux in the transformer core.

The steering square wave also drives the secondary-side active rectifier, so it is a port of its own. A line-frequency sign input is registered as the unfolding signal for the polarity-reversing output bridge. It is updated only at pair boundaries. The duty commands are computed elsewhere, and dead time is added downstream.

Top module: `eqpwm_modulator`

## Requirements
- R1: While reset is asserted, and in the first clock after its release, the pulse, steer, both gate and unfold outputs are all 0. The carrier count restarts at 0.
- R2: A carrier period lasts PERIOD clocks. The steer output is 0 in the first period after reset and inverts at every period boundary, so it is 1 in odd-numbered periods.
- R3: The duty command and the sign input are sampled only on the last clock of a carrier period. Their values on any other clock have no effect on any output.
- R4: Periods are paired as (0,1), (2,3) and so on. For a pair starting at period q ≥ 2, the active width is floor((cmd[q-1] + cmd[q-2]) / 2), where cmd[p] is the command sampled at the end of period p. The sum is formed one bit wider than a command, so it cannot overflow. The width is 0 in periods 0 and 1.
- R5: The active width changes only at the start of an even period. It stays constant through both periods of the pair.
- R6: In clock c of a period (c = 0 … PERIOD-1), the pulse output is 1 exactly when c < width. A width of 0 gives no pulse, and a width of PERIOD or more keeps the pulse high for the whole period.
- R7: gate_a equals pulse AND steer, and gate_b equals pulse AND NOT steer. The two gates are never 1 together.
- R8: Within every pair, gate_a and gate_b are high for the same number of clocks.
- R9: The unfold output takes the sign input sampled on the last clock of an odd period. It changes at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_cmd | input | DUTY_W | Duty command in clocks, sampled on the last clock of a period |
| sign_in | input | 1 | Polarity of the reference, sampled at the end of a pair |
| pulse_out | output | 1 | Rectified sinusoidal PWM pulse train |
| steer_out | output | 1 | Half-rate steering square wave, also the rectifier drive |
| gate_a | output | 1 | Primary diagonal enable, pulse AND steer |
| gate_b | output | 1 | Primary diagonal enable, pulse AND NOT steer |
| unfold_out | output | 1 | Line-frequency polarity for the unfolding bridge |

## Verification
The bench pays most attention to where the pair boundary falls. A design that loaded the new width at the start of the odd period, or that averaged the wrong two commands, would give the two diagonals of a pair unequal pulses, and both the per-clock comparison and the per-pair balance count would catch it. Garbage is driven on the command and sign inputs on every clock except the sampling one, so a design that sampled them at any other moment produces wrong widths or an early polarity change. The command sequence covers the width edges: zero, PERIOD-1, exactly PERIOD, values far above PERIOD, and odd sums whose half must truncate. An off-by-one compare or a sum that drops its carry would show up as a pulse one clock long or short. A reset in the middle of the run checks that the carrier restarts with steer low.

// File: rtl/eqpwm_pkg.sv
package eqpwm_pkg;

   // Position of a carrier period inside its pair
   typedef enum logic {
      PH_EVEN = 1'b0,
      PH_ODD  = 1'b1
   } pair_phase_e;

   // Counter width able to hold 0 .. period-1
   function automatic int cnt_width(input int period);
      return (period > 1) ? $clog2(period) : 1;
   endfunction

endpackage

// File: rtl/carrier_timer.sv
module carrier_timer
   import eqpwm_pkg::*;
#(
   parameter int PERIOD = 4000,
   parameter int CNT_W  = cnt_width(PERIOD)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt,
   output logic             period_end,
   output logic             pair_end,
   output pair_phase_e      phase
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   initial begin
      assert (PERIOD >= 2) else $error("carrier_timer: PERIOD must be at least 2");
      assert ((1 << CNT_W) >= PERIOD) else $error("carrier_timer: CNT_W too narrow");
   end

   assign period_end = (cnt == LAST);
   assign pair_end   = period_end && (phase == PH_ODD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= PH_EVEN;
      end else if (period_end) begin
         cnt   <= '0;
         phase <= (phase == PH_EVEN) ? PH_ODD : PH_EVEN;
      end else begin
         cnt   <= cnt + 1'b1;
      end
   end

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);

   // R2
   phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      period_end |=> (phase != $past(phase)));

   // R2
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !period_end |=> $stable(phase));

endmodule

// File: rtl/width_equalizer.sv
module width_equalizer #(
   parameter int DUTY_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_en,
   input  logic              load_en,
   input  logic [DUTY_W-1:0] cmd,
   output logic [DUTY_W-1:0] width
);

   localparam int SUM_W = DUTY_W + 1;

   initial begin
      assert (DUTY_W >= 1) else $error("width_equalizer: DUTY_W must be positive");
   end

   logic [DUTY_W-1:0] prev_cmd;
   logic [SUM_W-1:0]  pair_sum;
   logic [DUTY_W-1:0] pair_avg;

   // Newest command is on the input at the sampling edge; the older one is held.
   assign pair_sum = {1'b0, cmd} + {1'b0, prev_cmd};
   assign pair_avg = pair_sum[SUM_W-1:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_cmd <= '0;
      end else if (sample_en) begin
         prev_cmd <= cmd;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width <= '0;
      end else if (load_en) begin
         width <= pair_avg;
      end
   end

   // R3
   hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_en |=> $stable(prev_cmd));

   // R5
   width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> $stable(width));

   // R4
   width_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (width <= (($past(cmd) > $past(prev_cmd)) ? $past(cmd) : $past(prev_cmd))));

endmodule

// File: rtl/pulse_compare.sv
module pulse_compare #(
   parameter int CNT_W  = 12,
   parameter int DUTY_W = 16
) (
   input  logic [CNT_W-1:0]  cnt,
   input  logic [DUTY_W-1:0] width,
   input  logic              steer,
   output logic              pulse,
   output logic              diag_a,
   output logic              diag_b
);

   localparam int CMP_W = (DUTY_W > CNT_W) ? DUTY_W : CNT_W;

   logic [CMP_W-1:0] cnt_x;
   logic [CMP_W-1:0] width_x;

   generate
      if (DUTY_W > CNT_W) begin : g_pad_cnt
         assign cnt_x   = {{(DUTY_W - CNT_W){1'b0}}, cnt};
         assign width_x = width;
      end else if (DUTY_W == CNT_W) begin : g_same
         assign cnt_x   = cnt;
         assign width_x = width;
      end else begin : g_pad_width
         assign cnt_x   = cnt;
         assign width_x = {{(CNT_W - DUTY_W){1'b0}}, width};
      end
   endgenerate

   assign pulse  = (cnt_x < width_x);
   assign diag_a = pulse & steer;
   assign diag_b = pulse & ~steer;

endmodule

// File: rtl/eqpwm_modulator.sv
module eqpwm_modulator
   import eqpwm_pkg::*;
#(
   parameter int PERIOD = 4000,
   parameter int DUTY_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DUTY_W-1:0] duty_cmd,
   input  logic              sign_in,
   output logic              pulse_out,
   output logic              steer_out,
   output logic              gate_a,
   output logic              gate_b,
   output logic              unfold_out
);

   localparam int CNT_W = cnt_width(PERIOD);

   logic [CNT_W-1:0]  cnt;
   logic              period_end;
   logic              pair_end;
   pair_phase_e       phase;
   logic [DUTY_W-1:0] width;
   logic              unfold_q;

   carrier_timer #(
      .PERIOD (PERIOD),
      .CNT_W  (CNT_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt        (cnt),
      .period_end (period_end),
      .pair_end   (pair_end),
      .phase      (phase)
   );

   width_equalizer #(
      .DUTY_W (DUTY_W)
   ) u_equalizer (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_en (period_end),
      .load_en   (pair_end),
      .cmd       (duty_cmd),
      .width     (width)
   );

   assign steer_out = (phase == PH_ODD);

   pulse_compare #(
      .CNT_W  (CNT_W),
      .DUTY_W (DUTY_W)
   ) u_compare (
      .cnt    (cnt),
      .width  (width),
      .steer  (steer_out),
      .pulse  (pulse_out),
      .diag_a (gate_a),
      .diag_b (gate_b)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unfold_q <= 1'b0;
      end else if (pair_end) begin
         unfold_q <= sign_in;
      end
   end

   assign unfold_out = unfold_q;

   // R7
   gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_a && gate_b));

   // R7
   gate_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_out |-> (gate_a || gate_b));

   // R9
   unfold_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pair_end |=> $stable(unfold_out));

   // R6
   pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_out) |-> (cnt == '0));

endmodule

// File: tb/eqpwm_modulator_tb.sv
`timescale 1ns/1ps
module eqpwm_modulator_tb;

   localparam int P      = 12;
   localparam int DW     = 6;
   localparam int NPER   = 64;
   localparam int WDOG   = 100000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] duty_cmd = '0;
   logic          sign_in = 1'b0;
   logic          pulse_out, steer_out, gate_a, gate_b, unfold_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   int cmd_seq  [NPER];
   bit sign_seq [NPER];

   always #2.5 clk = ~clk;

   eqpwm_modulator #(.PERIOD(P), .DUTY_W(DW)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .duty_cmd   (duty_cmd),
      .sign_in    (sign_in),
      .pulse_out  (pulse_out),
      .steer_out  (steer_out),
      .gate_a     (gate_a),
      .gate_b     (gate_b),
      .unfold_out (unfold_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_width(input int p);
      int q;
      if (p < 2) return 0;
      q = p - (p % 2);
      return (cmd_seq[q-1] + cmd_seq[q-2]) / 2;
   endfunction

   function automatic int exp_unfold(input int p);
      int q;
      if (p < 2) return 0;
      q = p - (p % 2);
      return int'(sign_seq[q-1]);
   endfunction

   initial begin
      int cnt_cyc = 0;
      while (!done) begin
         @(posedge clk);
         cnt_cyc++;
         if (cnt_cyc > WDOG && !done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cnt_cyc, WDOG);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
         end
      end
   end

   initial begin
      int ca, cb, w;
      for (int p = 0; p < NPER; p++) begin
         cmd_seq[p]  = (p * 29 + 7) % 64;
         sign_seq[p] = ((p / 5) % 2) == 1;
      end
      // boundary widths: 0, full (63 > P), exactly P, P-1 via odd sum, 0 via truncation, 1
      cmd_seq[0] = 0;   cmd_seq[1] = 0;
      cmd_seq[2] = 63;  cmd_seq[3] = 63;
      cmd_seq[4] = 12;  cmd_seq[5] = 12;
      cmd_seq[6] = 11;  cmd_seq[7] = 12;
      cmd_seq[8] = 1;   cmd_seq[9] = 0;
      cmd_seq[10] = 1;  cmd_seq[11] = 2;

      // R1: outputs during reset
      repeat (3) @(negedge clk);
      chk(pulse_out == 0 && gate_a == 0 && gate_b == 0, "R1 pulse/gates in reset",
          int'({pulse_out, gate_a, gate_b}), 0);
      chk(steer_out == 0 && unfold_out == 0, "R1 steer/unfold in reset",
          int'({steer_out, unfold_out}), 0);
      rst_n = 1'b1;

      ca = 0; cb = 0;
      for (int p = 0; p < NPER; p++) begin
         w = exp_width(p);
         if (p % 2 == 0) begin ca = 0; cb = 0; end
         for (int c = 0; c < P; c++) begin
            // R3: garbage except on the sampling clock
            if (c == P - 1) begin
               duty_cmd = DW'(cmd_seq[p]);
               sign_in  = sign_seq[p];
            end else begin
               duty_cmd = ~DW'(cmd_seq[p]);
               sign_in  = ~sign_seq[p];
            end
            #0.5;
            // R4 R5 R6: pulse shape from equalized width
            chk(pulse_out == (c < w), "R6/R4 pulse", int'(pulse_out), int'(c < w));
            // R2: steer per period
            chk(steer_out == (p % 2), "R2 steer", int'(steer_out), p % 2);
            // R7: gate forming
            chk(gate_a == ((c < w) && (p % 2 == 1)), "R7 gate_a", int'(gate_a),
                int'((c < w) && (p % 2 == 1)));
            chk(gate_b == ((c < w) && (p % 2 == 0)), "R7 gate_b", int'(gate_b),
                int'((c < w) && (p % 2 == 0)));
            // R9 R3: unfold from sign sampled at pair end
            chk(unfold_out == exp_unfold(p), "R9 unfold", int'(unfold_out), exp_unfold(p));
            ca += int'(gate_a);
            cb += int'(gate_b);
            @(negedge clk);
         end
         if (p % 2 == 1) begin
            // R8: equal volt-seconds per pair
            chk(ca == cb, "R8 pair balance", ca, cb);
            chk(cb == ((w < P) ? w : P), "R5 pair width held", cb, (w < P) ? w : P);
         end
      end

      // R1: reset mid-run restarts carrier
      rst_n = 1'b0;
      #0.5;
      chk(pulse_out == 0 && steer_out == 0 && unfold_out == 0, "R1 async reset",
          int'({pulse_out, steer_out, unfold_out}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      duty_cmd = '1;
      for (int c = 0; c < P; c++) begin
         #0.5;
         chk(steer_out == 0, "R1 steer after restart", int'(steer_out), 0);
         chk(pulse_out == 0, "R1 no pulse after restart", int'(pulse_out), 0);
         @(negedge clk);
      end
      #0.5;
      chk(steer_out == 1, "R2 steer toggles after PERIOD clocks", int'(steer_out), 1);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule